// File: doc/BRIEF.md
# Eight-Slot Dual-Packet Instruction Decoder

This block sits in the front end of a wide out-of-order core. Each cycle it receives a bundle of eight 32-bit instructions. Any compressed forms have already been expanded. It decodes all eight slots in parallel with pure combinational logic, so the result is ready in the same cycle the bundle arrives. Each slot's decode path sees only that slot's 32 bits. No signal passes between slots.

For every slot the block drives two packets and one steering bit. The scalar packet gives a major-opcode class, the raw register specifiers with their use flags, and a sign-extended immediate. The vector packet gives a coarse vector class, the vector register specifiers, the mask bit, a store flag, and two role flags. One role flag marks an instruction that writes the vector type. The other marks an instruction that depends on the vector type. The decoder keeps no vector-type state. It only labels producers and consumers, and leaves ordering to rename. The steering bit tells the next stage which of the two packets is meaningful. For a vector instruction, the scalar packet flags all three scalar register fields as used, which is a deliberately conservative marking.

Top module: `idec_bundle`

## Requirements
- R1: Slot N occupies `inst_bundle[32N+31:32N]` and drives bit N (or field N) of every output. Each slot's outputs depend only on that slot's instruction bits, and the outputs follow the inputs within the same cycle with no storage.
- R2: When bits [1:0] are 11, `sc_class` takes these values. It is 1 for major opcode 0000011, 2 for 0100011, 3 for 0010011 and 4 for 0110011. It is 5 for 0110111, 6 for 0010111, 7 for 1101111, 8 for 1100111 and 9 for 1100011. It is 10 for 1110011, 11 for 0001111, 12 for 0011011, 13 for 0111011 and 14 for 0101111. It is 15 for scalar floating point, meaning 1010011, 1000011, 1000111, 1001011, 1001111, or 0000111/0100111 with a scalar width. It is 16 for every vector instruction.
- R3: If bits [1:0] are not 11, or the opcode is not listed in R2, or an opcode-1010111 instruction has funct3 111 with bits [31:30]=10 and bits [29:25] not zero, the slot is illegal. In that case `sc_illegal`=1, `is_vector`=0, and every other output field of the slot is zero.
- R4: For every legal slot, `sc_rd`, `sc_rs1` and `sc_rs2` carry bits [11:7], [19:15] and [24:20]. The use flags are {rd,rs1,rs2} = 110 for classes 1, 3, 8, 10 and 12. They are 011 for classes 2 and 9, 100 for classes 5, 6 and 7, and 000 for class 11. They are 111 for classes 4, 13, 14 and 16, and for class 15 except that a scalar FP load gives 110 and a scalar FP store gives 011.
- R5: `sc_imm` is the sign-extended I-type immediate for classes 1, 3, 8, 10, 12 and scalar FP loads. It is the S-type immediate for class 2 and scalar FP stores, the B-type immediate for class 9, the U-type immediate for classes 5 and 6, and the J-type immediate for class 7. It is zero otherwise.
- R6: Any vector instruction sets `is_vector`=1 and `sc_class`=16, sets all three scalar use flags, and has `sc_imm`=0.
- R7: For opcode 1010111, `vec_class` is 1 (integer ALU) when funct3 is 000, 010, 011, 100 or 110, and 2 (FP ALU) when funct3 is 001 or 101. `vec_vd`, `vec_vs2` and `vec_vm` carry bits [11:7], [24:20] and [25]. `vec_vs1` carries bits [19:15] for funct3 000, 001 and 010, and is zero for the scalar- or immediate-source groups 011, 100, 101 and 110.
- R8: For opcode 1010111 with funct3 111, the legal configuration forms are: bit 31 = 0; bits [31:30] = 11; or bits [31:25] = 1000000. These give `vec_class`=3 with `vec_vtype_wr`=1, `vec_vtype_rd`=0, and zero vd, vs1, vs2, vm and store.
- R9: Opcode 0000111 or 0100111 with width bits [14:12] of 000, 101, 110 or 111 is a vector memory access. It gives `vec_class`=4, `vec_vd` = bits [11:7], `vec_vs2` = bits [24:20], `vec_vs1`=0 and `vec_vm` = bit 25. `vec_store` is 1 only for 0100111.
- R10: Every vector instruction other than a configuration sets `vec_vtype_rd`=1 and `vec_vtype_wr`=0.
- R11: On a slot that is not vector, the vector packet is a placeholder. `vec_class`, all vector register fields, `vec_vm`, `vec_store` and both role flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_bundle | input | 256 | Eight expanded 32-bit instructions, slot 0 in the low bits |
| sc_class | output | 40 | Scalar major-opcode class per slot, 5 bits each |
| sc_illegal | output | 8 | Illegal-instruction flag per slot |
| sc_rd | output | 40 | Destination specifier per slot |
| sc_rs1 | output | 40 | First source specifier per slot |
| sc_rs2 | output | 40 | Second source specifier per slot |
| sc_rd_use | output | 8 | Destination field is written |
| sc_rs1_use | output | 8 | First source field is read |
| sc_rs2_use | output | 8 | Second source field is read |
| sc_imm | output | 256 | Sign-extended immediate per slot |
| vec_class | output | 24 | Coarse vector class per slot, 3 bits each |
| vec_vd | output | 40 | Vector destination (or store data) register |
| vec_vs1 | output | 40 | Vector source 1, zero when the operand is not a vector register |
| vec_vs2 | output | 40 | Vector source 2 (index or stride field for memory) |
| vec_vm | output | 8 | Mask bit passed through |
| vec_store | output | 8 | Vector memory access is a store |
| vec_vtype_wr | output | 8 | Slot produces a new vector type |
| vec_vtype_rd | output | 8 | Slot consumes the current vector type |
| is_vector | output | 8 | Steering: vector packet is the meaningful one |

## Verification
The assertions hold several invariants on every slot at all times. An illegal slot is fully quiet and never steered to vector. A non-vector slot carries an all-zero vector placeholder. A vector slot carries the conservative scalar markings. Each vector slot holds exactly one vector-type role, and only the configuration class writes the type. Other properties cannot be seen from invariants and need the bench's scenarios. These are the exact opcode-to-class map, the immediate formats at their sign boundaries, clearing of vs1 for scalar-source groups, splitting of the memory width code, and rejection of reserved configuration forms. The same holds for slot isolation: the bench shows it by changing one slot of a bundle and confirming that the other seven slots' outputs stay the same.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int unsigned ILEN   = 32;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned SCLS_W = 5;
    localparam int unsigned VCLS_W = 3;

    typedef enum logic [6:0] {
        OPC_LOAD     = 7'b0000011,
        OPC_LOAD_FP  = 7'b0000111,
        OPC_MISC_MEM = 7'b0001111,
        OPC_OP_IMM   = 7'b0010011,
        OPC_AUIPC    = 7'b0010111,
        OPC_OP_IMM32 = 7'b0011011,
        OPC_STORE    = 7'b0100011,
        OPC_STORE_FP = 7'b0100111,
        OPC_AMO      = 7'b0101111,
        OPC_OP       = 7'b0110011,
        OPC_LUI      = 7'b0110111,
        OPC_OP32     = 7'b0111011,
        OPC_FMADD    = 7'b1000011,
        OPC_FMSUB    = 7'b1000111,
        OPC_FNMSUB   = 7'b1001011,
        OPC_FNMADD   = 7'b1001111,
        OPC_OP_FP    = 7'b1010011,
        OPC_OP_V     = 7'b1010111,
        OPC_BRANCH   = 7'b1100011,
        OPC_JALR     = 7'b1100111,
        OPC_JAL      = 7'b1101111,
        OPC_SYSTEM   = 7'b1110011
    } major_opc_e;

    typedef enum logic [SCLS_W-1:0] {
        SC_ILLEGAL = 5'd0,
        SC_LOAD    = 5'd1,
        SC_STORE   = 5'd2,
        SC_OPIMM   = 5'd3,
        SC_OP      = 5'd4,
        SC_LUI     = 5'd5,
        SC_AUIPC   = 5'd6,
        SC_JAL     = 5'd7,
        SC_JALR    = 5'd8,
        SC_BRANCH  = 5'd9,
        SC_SYSTEM  = 5'd10,
        SC_FENCE   = 5'd11,
        SC_OPIMM32 = 5'd12,
        SC_OP32    = 5'd13,
        SC_AMO     = 5'd14,
        SC_FP      = 5'd15,
        SC_VEC     = 5'd16
    } sclass_e;

    typedef enum logic [2:0] {
        IMM_NONE = 3'd0,
        IMM_I    = 3'd1,
        IMM_S    = 3'd2,
        IMM_B    = 3'd3,
        IMM_U    = 3'd4,
        IMM_J    = 3'd5
    } imm_fmt_e;

    typedef enum logic [VCLS_W-1:0] {
        VC_NONE = 3'd0,
        VC_IALU = 3'd1,
        VC_FALU = 3'd2,
        VC_CFG  = 3'd3,
        VC_MEM  = 3'd4
    } vclass_e;

    // Per-opcode summary produced by the major-opcode stage.
    typedef struct packed {
        sclass_e  cls;
        imm_fmt_e fmt;
        logic     rd_use;
        logic     rs1_use;
        logic     rs2_use;
    } major_info_t;

    typedef struct packed {
        sclass_e           cls;
        logic              illegal;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic              rd_use;
        logic              rs1_use;
        logic              rs2_use;
        logic [ILEN-1:0]   imm;
    } scalar_pkt_t;

    typedef struct packed {
        vclass_e           cls;
        logic [REG_W-1:0]  vd;
        logic [REG_W-1:0]  vs1;
        logic [REG_W-1:0]  vs2;
        logic              vm;
        logic              store;
        logic              vtype_wr;
        logic              vtype_rd;
    } vec_pkt_t;

    function automatic major_info_t mk_info(input sclass_e c, input imm_fmt_e f,
                                            input logic [2:0] uses);
        major_info_t m;
        m.cls     = c;
        m.fmt     = f;
        m.rd_use  = uses[2];
        m.rs1_use = uses[1];
        m.rs2_use = uses[0];
        return m;
    endfunction

    function automatic logic [ILEN-1:0] imm_extract(input logic [ILEN-1:0] inst,
                                                     input imm_fmt_e fmt);
        logic [ILEN-1:0] imm;
        case (fmt)
            IMM_I:   imm = {{20{inst[31]}}, inst[31:20]};
            IMM_S:   imm = {{20{inst[31]}}, inst[31:25], inst[11:7]};
            IMM_B:   imm = {{19{inst[31]}}, inst[31], inst[7], inst[30:25],
                            inst[11:8], 1'b0};
            IMM_U:   imm = {inst[31:12], 12'b0};
            IMM_J:   imm = {{11{inst[31]}}, inst[31], inst[19:12], inst[20],
                            inst[30:21], 1'b0};
            default: imm = '0;
        endcase
        return imm;
    endfunction

    // Width codes on the FP load/store opcodes that denote a vector access.
    function automatic logic is_vmem_width(input logic [2:0] w);
        return (w == 3'b000) || (w[2] && (w[1] || w[0]));
    endfunction

    function automatic logic vgrp_is_fp(input logic [2:0] f3);
        return (f3 == 3'b001) || (f3 == 3'b101);
    endfunction

    // Groups whose first operand is a scalar register or an immediate.
    function automatic logic vgrp_scalar_src(input logic [2:0] f3);
        return (f3 == 3'b011) || (f3 == 3'b100) || (f3 == 3'b101) || (f3 == 3'b110);
    endfunction

    function automatic logic vcfg_form_ok(input logic [ILEN-1:0] inst);
        return !inst[31] || inst[30] || (inst[29:25] == 5'b00000);
    endfunction

endpackage

// File: rtl/idec_major.sv
module idec_major
    import idec_pkg::*;
(
    input  logic [ILEN-1:0] inst,
    output major_info_t     info,
    output logic            opv_hit,
    output logic            vmem_hit
);

    logic [2:0] width;
    assign width = inst[14:12];

    always_comb begin
        info     = mk_info(SC_ILLEGAL, IMM_NONE, 3'b000);
        opv_hit  = 1'b0;
        vmem_hit = 1'b0;
        if (inst[1:0] == 2'b11) begin
            case (inst[6:0])
                OPC_LOAD:     info = mk_info(SC_LOAD,    IMM_I,    3'b110);
                OPC_STORE:    info = mk_info(SC_STORE,   IMM_S,    3'b011);
                OPC_OP_IMM:   info = mk_info(SC_OPIMM,   IMM_I,    3'b110);
                OPC_OP:       info = mk_info(SC_OP,      IMM_NONE, 3'b111);
                OPC_LUI:      info = mk_info(SC_LUI,     IMM_U,    3'b100);
                OPC_AUIPC:    info = mk_info(SC_AUIPC,   IMM_U,    3'b100);
                OPC_JAL:      info = mk_info(SC_JAL,     IMM_J,    3'b100);
                OPC_JALR:     info = mk_info(SC_JALR,    IMM_I,    3'b110);
                OPC_BRANCH:   info = mk_info(SC_BRANCH,  IMM_B,    3'b011);
                OPC_SYSTEM:   info = mk_info(SC_SYSTEM,  IMM_I,    3'b110);
                OPC_MISC_MEM: info = mk_info(SC_FENCE,   IMM_NONE, 3'b000);
                OPC_OP_IMM32: info = mk_info(SC_OPIMM32, IMM_I,    3'b110);
                OPC_OP32:     info = mk_info(SC_OP32,    IMM_NONE, 3'b111);
                OPC_AMO:      info = mk_info(SC_AMO,     IMM_NONE, 3'b111);
                OPC_OP_FP, OPC_FMADD, OPC_FMSUB, OPC_FNMSUB, OPC_FNMADD:
                              info = mk_info(SC_FP,      IMM_NONE, 3'b111);
                OPC_LOAD_FP: begin
                    if (is_vmem_width(width)) begin
                        info     = mk_info(SC_VEC, IMM_NONE, 3'b111);
                        vmem_hit = 1'b1;
                    end else begin
                        info     = mk_info(SC_FP, IMM_I, 3'b110);
                    end
                end
                OPC_STORE_FP: begin
                    if (is_vmem_width(width)) begin
                        info     = mk_info(SC_VEC, IMM_NONE, 3'b111);
                        vmem_hit = 1'b1;
                    end else begin
                        info     = mk_info(SC_FP, IMM_S, 3'b011);
                    end
                end
                OPC_OP_V: begin
                    info    = mk_info(SC_VEC, IMM_NONE, 3'b111);
                    opv_hit = 1'b1;
                end
                default:      info = mk_info(SC_ILLEGAL, IMM_NONE, 3'b000);
            endcase
        end
    end

endmodule

// File: rtl/idec_vclass.sv
module idec_vclass
    import idec_pkg::*;
(
    input  logic [ILEN-1:0] inst,
    input  logic            opv_hit,
    input  logic            vmem_hit,
    output vec_pkt_t        vpkt,
    output logic            vec_ok
);

    logic [2:0] f3;
    assign f3 = inst[14:12];

    always_comb begin
        vpkt   = '0;
        vec_ok = 1'b1;
        if (opv_hit) begin
            if (f3 == 3'b111) begin
                // Configuration: writes the vector type, names no vector register.
                vec_ok        = vcfg_form_ok(inst);
                vpkt.cls      = VC_CFG;
                vpkt.vtype_wr = 1'b1;
            end else begin
                vpkt.cls      = vgrp_is_fp(f3) ? VC_FALU : VC_IALU;
                vpkt.vd       = inst[11:7];
                vpkt.vs2      = inst[24:20];
                vpkt.vs1      = vgrp_scalar_src(f3) ? '0 : inst[19:15];
                vpkt.vm       = inst[25];
                vpkt.vtype_rd = 1'b1;
            end
        end else if (vmem_hit) begin
            vpkt.cls      = VC_MEM;
            vpkt.vd       = inst[11:7];
            vpkt.vs2      = inst[24:20];
            vpkt.vm       = inst[25];
            vpkt.store    = inst[5];
            vpkt.vtype_rd = 1'b1;
        end
    end

endmodule

// File: rtl/idec_slot.sv
module idec_slot
    import idec_pkg::*;
(
    input  logic [ILEN-1:0] inst,
    output scalar_pkt_t     spkt,
    output vec_pkt_t        vpkt,
    output logic            is_vec
);

    major_info_t info;
    logic        opv_hit;
    logic        vmem_hit;
    vec_pkt_t    vraw;
    logic        vec_ok;
    logic        legal;

    idec_major u_major (
        .inst     (inst),
        .info     (info),
        .opv_hit  (opv_hit),
        .vmem_hit (vmem_hit)
    );

    idec_vclass u_vclass (
        .inst     (inst),
        .opv_hit  (opv_hit),
        .vmem_hit (vmem_hit),
        .vpkt     (vraw),
        .vec_ok   (vec_ok)
    );

    assign legal = (info.cls != SC_ILLEGAL) && vec_ok;

    always_comb begin
        spkt   = '0;
        vpkt   = '0;
        is_vec = 1'b0;
        if (!legal) begin
            spkt.illegal = 1'b1;
        end else begin
            spkt.cls     = info.cls;
            spkt.rd      = inst[11:7];
            spkt.rs1     = inst[19:15];
            spkt.rs2     = inst[24:20];
            spkt.rd_use  = info.rd_use;
            spkt.rs1_use = info.rs1_use;
            spkt.rs2_use = info.rs2_use;
            spkt.imm     = imm_extract(inst, info.fmt);
            is_vec       = opv_hit || vmem_hit;
            if (is_vec) begin
                vpkt = vraw;
            end
        end
    end

endmodule

// File: rtl/idec_bundle.sv
module idec_bundle
    import idec_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS*ILEN-1:0]   inst_bundle,
    output logic [NUM_SLOTS*SCLS_W-1:0] sc_class,
    output logic [NUM_SLOTS-1:0]        sc_illegal,
    output logic [NUM_SLOTS*REG_W-1:0]  sc_rd,
    output logic [NUM_SLOTS*REG_W-1:0]  sc_rs1,
    output logic [NUM_SLOTS*REG_W-1:0]  sc_rs2,
    output logic [NUM_SLOTS-1:0]        sc_rd_use,
    output logic [NUM_SLOTS-1:0]        sc_rs1_use,
    output logic [NUM_SLOTS-1:0]        sc_rs2_use,
    output logic [NUM_SLOTS*ILEN-1:0]   sc_imm,
    output logic [NUM_SLOTS*VCLS_W-1:0] vec_class,
    output logic [NUM_SLOTS*REG_W-1:0]  vec_vd,
    output logic [NUM_SLOTS*REG_W-1:0]  vec_vs1,
    output logic [NUM_SLOTS*REG_W-1:0]  vec_vs2,
    output logic [NUM_SLOTS-1:0]        vec_vm,
    output logic [NUM_SLOTS-1:0]        vec_store,
    output logic [NUM_SLOTS-1:0]        vec_vtype_wr,
    output logic [NUM_SLOTS-1:0]        vec_vtype_rd,
    output logic [NUM_SLOTS-1:0]        is_vector
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        scalar_pkt_t sp;
        vec_pkt_t    vp;
        logic        iv;

        idec_slot u_slot (
            .inst   (inst_bundle[s*ILEN +: ILEN]),
            .spkt   (sp),
            .vpkt   (vp),
            .is_vec (iv)
        );

        assign sc_class[s*SCLS_W +: SCLS_W] = sp.cls;
        assign sc_illegal[s]                = sp.illegal;
        assign sc_rd[s*REG_W +: REG_W]      = sp.rd;
        assign sc_rs1[s*REG_W +: REG_W]     = sp.rs1;
        assign sc_rs2[s*REG_W +: REG_W]     = sp.rs2;
        assign sc_rd_use[s]                 = sp.rd_use;
        assign sc_rs1_use[s]                = sp.rs1_use;
        assign sc_rs2_use[s]                = sp.rs2_use;
        assign sc_imm[s*ILEN +: ILEN]       = sp.imm;
        assign vec_class[s*VCLS_W +: VCLS_W] = vp.cls;
        assign vec_vd[s*REG_W +: REG_W]     = vp.vd;
        assign vec_vs1[s*REG_W +: REG_W]    = vp.vs1;
        assign vec_vs2[s*REG_W +: REG_W]    = vp.vs2;
        assign vec_vm[s]                    = vp.vm;
        assign vec_store[s]                 = vp.store;
        assign vec_vtype_wr[s]              = vp.vtype_wr;
        assign vec_vtype_rd[s]              = vp.vtype_rd;
        assign is_vector[s]                 = iv;
    end

endmodule

// File: rtl/idec_bundle_chk.sv
module idec_bundle_chk
    import idec_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input logic [NUM_SLOTS*ILEN-1:0]   inst_bundle,
    input logic [NUM_SLOTS*SCLS_W-1:0] sc_class,
    input logic [NUM_SLOTS-1:0]        sc_illegal,
    input logic [NUM_SLOTS-1:0]        sc_rd_use,
    input logic [NUM_SLOTS-1:0]        sc_rs1_use,
    input logic [NUM_SLOTS-1:0]        sc_rs2_use,
    input logic [NUM_SLOTS*ILEN-1:0]   sc_imm,
    input logic [NUM_SLOTS*VCLS_W-1:0] vec_class,
    input logic [NUM_SLOTS-1:0]        vec_store,
    input logic [NUM_SLOTS-1:0]        vec_vtype_wr,
    input logic [NUM_SLOTS-1:0]        vec_vtype_rd,
    input logic [NUM_SLOTS-1:0]        is_vector
);

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            // R3: an uncompressed-form violation can never decode as legal
            assert_lowbits_illegal_R3: assert (inst_bundle[s*ILEN +: 2] == 2'b11 || sc_illegal[s])
                else $error("slot %0d low bits not 11 but decoded legal", s);
            // R3: an illegal slot is quiet and never steered to vector
            assert_illegal_quiet_R3: assert (!sc_illegal[s] ||
                    (!is_vector[s] && sc_class[s*SCLS_W +: SCLS_W] == '0 &&
                     !sc_rd_use[s] && !sc_rs1_use[s] && !sc_rs2_use[s] &&
                     sc_imm[s*ILEN +: ILEN] == '0))
                else $error("slot %0d illegal but not quiet", s);
            // R11: non-vector slots carry an empty vector packet
            assert_placeholder_R11: assert (is_vector[s] ||
                    (vec_class[s*VCLS_W +: VCLS_W] == '0 && !vec_store[s] &&
                     !vec_vtype_wr[s] && !vec_vtype_rd[s]))
                else $error("slot %0d scalar but vector packet populated", s);
            // R6: vector slots mark every scalar field conservatively
            assert_conservative_R6: assert (!is_vector[s] ||
                    (sc_class[s*SCLS_W +: SCLS_W] == SC_VEC && sc_rd_use[s] &&
                     sc_rs1_use[s] && sc_rs2_use[s] && sc_imm[s*ILEN +: ILEN] == '0))
                else $error("slot %0d vector without conservative marks", s);
            // R10: a vector slot holds exactly one vector-type role
            assert_one_role_R10: assert (!is_vector[s] || (vec_vtype_wr[s] ^ vec_vtype_rd[s]))
                else $error("slot %0d vector type role not unique", s);
            // R8: only the configuration class writes the vector type
            assert_cfg_producer_R8: assert ((vec_class[s*VCLS_W +: VCLS_W] == VC_CFG) == vec_vtype_wr[s])
                else $error("slot %0d producer flag disagrees with class", s);
        end
    end

endmodule

bind idec_bundle idec_bundle_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .inst_bundle  (inst_bundle),
    .sc_class     (sc_class),
    .sc_illegal   (sc_illegal),
    .sc_rd_use    (sc_rd_use),
    .sc_rs1_use   (sc_rs1_use),
    .sc_rs2_use   (sc_rs2_use),
    .sc_imm       (sc_imm),
    .vec_class    (vec_class),
    .vec_store    (vec_store),
    .vec_vtype_wr (vec_vtype_wr),
    .vec_vtype_rd (vec_vtype_rd),
    .is_vector    (is_vector)
);

// File: tb/idec_bundle_tb.sv
module idec_bundle_tb;

    localparam int NS         = 8;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 79;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS*32-1:0] bundle = '0;

    logic [NS*5-1:0]  sc_class, sc_rd, sc_rs1, sc_rs2, vec_vd, vec_vs1, vec_vs2;
    logic [NS-1:0]    sc_illegal, sc_rd_use, sc_rs1_use, sc_rs2_use;
    logic [NS*32-1:0] sc_imm;
    logic [NS*3-1:0]  vec_class;
    logic [NS-1:0]    vec_vm, vec_store, vec_vtype_wr, vec_vtype_rd, is_vector;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    int  dir_pos  = 0;

    idec_bundle #(.NUM_SLOTS(NS)) u_dut (
        .inst_bundle  (bundle),
        .sc_class     (sc_class),
        .sc_illegal   (sc_illegal),
        .sc_rd        (sc_rd),
        .sc_rs1       (sc_rs1),
        .sc_rs2       (sc_rs2),
        .sc_rd_use    (sc_rd_use),
        .sc_rs1_use   (sc_rs1_use),
        .sc_rs2_use   (sc_rs2_use),
        .sc_imm       (sc_imm),
        .vec_class    (vec_class),
        .vec_vd       (vec_vd),
        .vec_vs1      (vec_vs1),
        .vec_vs2      (vec_vs2),
        .vec_vm       (vec_vm),
        .vec_store    (vec_store),
        .vec_vtype_wr (vec_vtype_wr),
        .vec_vtype_rd (vec_vtype_rd),
        .is_vector    (is_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: expected slot outputs packed as
    // {class,illegal,rd,rs1,rs2,uses3,imm,vclass,vd,vs1,vs2,vm,store,wr,rd_dep,isvec}
    function automatic logic [PW-1:0] ref_slot(input logic [31:0] i);
        logic [4:0]  c = 0, rd = 0, r1 = 0, r2 = 0, vd = 0, v1 = 0, v2 = 0;
        logic [2:0]  u = 0, vc = 0;
        logic [31:0] im = 0;
        logic        il = 0, vm = 0, st = 0, wr = 0, dep = 0, isv = 0;
        int          op = int'(i[6:0]);
        int          f3 = int'(i[14:12]);
        logic [31:0] iI = {{20{i[31]}}, i[31:20]};
        logic [31:0] iS = {{20{i[31]}}, i[31:25], i[11:7]};
        logic [31:0] iB = {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
        logic [31:0] iU = {i[31:12], 12'h000};
        logic [31:0] iJ = {{11{i[31]}}, i[31], i[19:12], i[20], i[30:21], 1'b0};
        bit vmw = (f3 == 0) || (f3 >= 5);
        if (i[1:0] != 2'b11) il = 1;
        else case (op)
            'h03: begin c = 1;  u = 3'b110; im = iI; end
            'h23: begin c = 2;  u = 3'b011; im = iS; end
            'h13: begin c = 3;  u = 3'b110; im = iI; end
            'h33: begin c = 4;  u = 3'b111; end
            'h37: begin c = 5;  u = 3'b100; im = iU; end
            'h17: begin c = 6;  u = 3'b100; im = iU; end
            'h6f: begin c = 7;  u = 3'b100; im = iJ; end
            'h67: begin c = 8;  u = 3'b110; im = iI; end
            'h63: begin c = 9;  u = 3'b011; im = iB; end
            'h73: begin c = 10; u = 3'b110; im = iI; end
            'h0f: begin c = 11; u = 3'b000; end
            'h1b: begin c = 12; u = 3'b110; im = iI; end
            'h3b: begin c = 13; u = 3'b111; end
            'h2f: begin c = 14; u = 3'b111; end
            'h53, 'h43, 'h47, 'h4b, 'h4f: begin c = 15; u = 3'b111; end
            'h07, 'h27: begin
                if (vmw) begin
                    isv = 1; vc = 4; vd = i[11:7]; v2 = i[24:20]; vm = i[25];
                    st = (op == 'h27); dep = 1;
                end else if (op == 'h07) begin c = 15; u = 3'b110; im = iI; end
                else begin c = 15; u = 3'b011; im = iS; end
            end
            'h57: begin
                if (f3 == 7) begin
                    if (i[31:30] == 2'b10 && i[29:25] != 0) il = 1;
                    else begin isv = 1; vc = 3; wr = 1; end
                end else begin
                    isv = 1; vc = (f3 == 1 || f3 == 5) ? 3'd2 : 3'd1;
                    vd = i[11:7]; v2 = i[24:20]; vm = i[25]; dep = 1;
                    v1 = (f3 <= 2) ? i[19:15] : 5'd0;
                end
            end
            default: il = 1;
        endcase
        if (isv) begin c = 16; u = 3'b111; im = 0; end
        if (!il) begin rd = i[11:7]; r1 = i[19:15]; r2 = i[24:20]; end
        return {c, il, rd, r1, r2, u, im, vc, vd, v1, v2, vm, st, wr, dep, isv};
    endfunction

    function automatic logic [PW-1:0] got_slot(input int s);
        return {sc_class[s*5 +: 5], sc_illegal[s], sc_rd[s*5 +: 5], sc_rs1[s*5 +: 5],
                sc_rs2[s*5 +: 5], sc_rd_use[s], sc_rs1_use[s], sc_rs2_use[s],
                sc_imm[s*32 +: 32], vec_class[s*3 +: 3], vec_vd[s*5 +: 5],
                vec_vs1[s*5 +: 5], vec_vs2[s*5 +: 5], vec_vm[s], vec_store[s],
                vec_vtype_wr[s], vec_vtype_rd[s], is_vector[s]};
    endfunction

    task automatic check(input string tag, input int s, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s slot %0d actual=%h expected=%h", tag, s, act, exp);
        end
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [NS*32-1:0] b);
        @(posedge clk);
        #1 bundle = b;
        @(negedge clk);
    endtask

    function automatic logic [6:0] pick_opc(input int n);
        case (n % 22)
            0: return 7'h03;  1: return 7'h23;  2: return 7'h13;  3: return 7'h33;
            4: return 7'h37;  5: return 7'h17;  6: return 7'h6f;  7: return 7'h67;
            8: return 7'h63;  9: return 7'h73; 10: return 7'h0f; 11: return 7'h1b;
           12: return 7'h3b; 13: return 7'h2f; 14: return 7'h53; 15: return 7'h43;
           16: return 7'h47; 17: return 7'h4b; 18: return 7'h4f; 19: return 7'h07;
           20: return 7'h27; default: return 7'h57;
        endcase
    endfunction

    function automatic logic [31:0] gen_inst();
        logic [31:0] r = $urandom;
        int sel = int'($urandom % 8);
        case (sel)
            0:       return r;
            1, 2, 3: return {r[31:7], pick_opc(int'($urandom))};
            4, 5:    return {r[31:7], 7'h57};
            6:       return {r[31:15], 3'b111, r[11:7], 7'h57};
            default: return {r[31:7], ($urandom % 2 == 0) ? 7'h07 : 7'h27};
        endcase
    endfunction

    function automatic logic [NS*32-1:0] gen_bundle();
        logic [NS*32-1:0] b;
        for (int s = 0; s < NS; s++) b[s*32 +: 32] = gen_inst();
        return b;
    endfunction

    function automatic logic [31:0] opv(input logic [5:0] f6, input logic vmb,
                                        input logic [4:0] vs2, input logic [4:0] vs1,
                                        input logic [2:0] f3, input logic [4:0] vd);
        return {f6, vmb, vs2, vs1, f3, vd, 7'h57};
    endfunction

    // Directed instruction placed in a rotating slot among random neighbours.
    task automatic run_dir(input logic [31:0] ins, input string tag);
        logic [NS*32-1:0] b = gen_bundle();
        int pos = dir_pos % NS;
        dir_pos++;
        b[pos*32 +: 32] = ins;
        apply(b);
        for (int s = 0; s < NS; s++)
            check((s == pos) ? tag : "R1", s, got_slot(s), ref_slot(b[s*32 +: 32]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] saved [NS];
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: all-zero bundle has low bits 00, so every slot is illegal and quiet
        for (int s = 0; s < NS; s++)
            check("R3", s, got_slot(s), {5'd0, 1'b1, 73'd0});

        // R2/R4/R5: scalar classes with their field and immediate formats
        run_dir({12'hffd, 5'd6, 3'b000, 5'd5, 7'h13}, "R5");
        run_dir({12'h7ff, 5'd1, 3'b010, 5'd2, 7'h03}, "R4");
        run_dir({7'h40, 5'd9, 5'd8, 3'b010, 5'h1f, 7'h23}, "R5");
        run_dir({7'h00, 5'd3, 5'd4, 3'b000, 5'd7, 7'h33}, "R4");
        run_dir({20'hfffff, 5'd10, 7'h37}, "R5");
        run_dir({20'h80001, 5'd11, 7'h17}, "R5");
        run_dir({1'b1, 10'h3ff, 1'b1, 8'hff, 5'd1, 7'h6f}, "R5");
        run_dir({12'h800, 5'd2, 3'b000, 5'd3, 7'h67}, "R2");
        run_dir({7'h7f, 5'd5, 5'd6, 3'b001, 5'h1f, 7'h63}, "R5");
        run_dir({12'h300, 5'd0, 3'b010, 5'd1, 7'h73}, "R2");
        run_dir({12'h0ff, 5'd0, 3'b000, 5'd0, 7'h0f}, "R4");
        run_dir({12'h001, 5'd4, 3'b000, 5'd4, 7'h1b}, "R2");
        run_dir({7'h20, 5'd2, 5'd1, 3'b000, 5'd3, 7'h3b}, "R2");
        run_dir({7'h08, 5'd2, 5'd1, 3'b010, 5'd3, 7'h2f}, "R2");
        run_dir({7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'h53}, "R2");
        run_dir({5'd9, 2'b00, 5'd2, 5'd1, 3'b000, 5'd3, 7'h4f}, "R2");
        run_dir({12'h010, 5'd1, 3'b011, 5'd2, 7'h07}, "R9");
        run_dir({7'h01, 5'd2, 5'd1, 3'b010, 5'd3, 7'h27}, "R9");

        // R5: B-type immediate at its most negative value
        apply({NS{7'h00, 5'd1, 5'd2, 3'b000, 5'd0, 7'h63}} | {{(NS-1)*32{1'b0}}, 32'h80000000});
        check32("R5 branch min offset", sc_imm[31:0], 32'hfffff000);
        check32("R5 branch zero offset", sc_imm[63:32], 32'h00000000);

        // R3: illegal forms
        run_dir(32'h0000_7f81, "R3");
        run_dir(32'h1234_567f, "R3");
        run_dir({7'b1000001, 5'd0, 5'd1, 3'b111, 5'd2, 7'h57}, "R3");
        run_dir({7'b1011111, 5'd3, 5'd1, 3'b111, 5'd2, 7'h57}, "R3");

        // R7/R10/R6: every arithmetic group of the vector opcode
        for (int f = 0; f < 7; f++)
            run_dir(opv(6'h17, f[0], 5'd12, 5'd13, f[2:0], 5'd14), "R7");
        // R7: scalar-source group clears vs1
        apply({NS{opv(6'h00, 1'b1, 5'd4, 5'd31, 3'b100, 5'd6)}});
        check32("R7 vs1 cleared", {27'd0, vec_vs1[4:0]}, 32'd0);
        check32("R7 vd passed", {27'd0, vec_vd[4:0]}, 32'd6);

        // R8: the three legal configuration forms
        run_dir({1'b0, 11'h0d7, 5'd10, 3'b111, 5'd5, 7'h57}, "R8");
        run_dir({2'b11, 10'h0c3, 5'd4, 3'b111, 5'd5, 7'h57}, "R8");
        run_dir({7'b1000000, 5'd11, 5'd10, 3'b111, 5'd5, 7'h57}, "R8");

        // R9: vector memory, every vector width, both directions
        run_dir({6'h00, 1'b1, 5'd0, 5'd2, 3'b000, 5'd8, 7'h07}, "R9");
        run_dir({6'h02, 1'b0, 5'd3, 5'd2, 3'b101, 5'd8, 7'h07}, "R9");
        run_dir({6'h03, 1'b1, 5'd3, 5'd2, 3'b110, 5'd9, 7'h27}, "R9");
        run_dir({6'h01, 1'b0, 5'd7, 5'd2, 3'b111, 5'd9, 7'h27}, "R9");
        apply({NS{6'h00, 1'b1, 5'd0, 5'd2, 3'b110, 5'd8, 7'h27}});
        check32("R9 store flag", {31'd0, vec_store[0]}, 32'd1);
        check32("R10 consumer flag", {30'd0, vec_vtype_wr[0], vec_vtype_rd[0]}, 32'd1);

        // R11: scalar slots keep a zero vector packet
        run_dir({7'h00, 5'd31, 5'd31, 3'b111, 5'd31, 7'h33}, "R11");

        // R1: random mixed bundles
        for (int n = 0; n < 300; n++) begin
            logic [NS*32-1:0] b = gen_bundle();
            apply(b);
            for (int s = 0; s < NS; s++) check("R1", s, got_slot(s), ref_slot(b[s*32 +: 32]));
        end

        // R1: changing one slot leaves the others untouched
        for (int n = 0; n < 150; n++) begin
            logic [NS*32-1:0] b = gen_bundle();
            int k = int'($urandom % NS);
            apply(b);
            for (int s = 0; s < NS; s++) saved[s] = got_slot(s);
            b[k*32 +: 32] = ~b[k*32 +: 32] ^ gen_inst();
            apply(b);
            for (int s = 0; s < NS; s++) begin
                if (s == k) check("R1", s, got_slot(s), ref_slot(b[s*32 +: 32]));
                else        check("R1 isolation", s, got_slot(s), saved[s]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule